// File: doc/BRIEF.md
# Working Register File with Pointer Pairs and Data-Space Decode

This block stores the 32 eight-bit working registers of a small 8-bit RISC core. Each cycle the ALU datapath reads two operands through two independent combinational read ports and writes one result through a synchronous write port. Three fixed register pairs also act as 16-bit indirect address pointers (X, Y, Z). A dedicated word port updates a whole pair in one cycle, and each pair is shown as a full 16-bit word. The Z word also supplies the address for constant-table lookups from program memory.

The same registers are visible at the bottom of a unified data address space, so that load and store instructions can reach them like memory. Addresses just above the register window are decoded into a select and an index for a 64-entry I/O region, and the range above that into a select and an index for a 256-byte data SRAM. The read data for those regions comes back on dedicated inputs and is steered onto the data-space read bus.

Top module: `gpr_file`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into register `wr_idx` at the rising clock edge. Both read ports return the stored contents of registers `rd_a_idx` and `rd_b_idx` independently.
- R2: Read ports are write-through. A read of a register that is being written in the same cycle returns the value that will be stored at the next edge.
- R3: `ptr_x` = {r27, r26}, `ptr_y` = {r29, r28} and `ptr_z` = {r31, r30}, with the lower-numbered register as the low byte. The pointers reflect ALU and data-space writes to those registers. `ptr_z` also serves as the table-lookup address.
- R4: With `ptr_we` high, `ptr_sel` 0/1/2 selects X/Y/Z and both bytes take `ptr_wdata` at the edge. The pointer write wins over an ALU or data-space write to the same register. `ptr_sel` 3 changes no register.
- R5: Data-space addresses 0x00 to 0x1F read and write registers 0 to 31. A data-space write wins over an ALU write to the same register in the same cycle.
- R6: Addresses 0x20 to 0x5F raise `io_sel` with `io_idx` = address − 0x20. A read returns `io_rdata`, and a write changes no register.
- R7: Addresses 0x60 to 0x15F raise `sram_sel` with `sram_idx` = address − 0x60. A read returns `sram_rdata`.
- R8: Addresses from 0x160 upward raise no select. A read there returns 0x00, and a write there changes no register.
- R9: An active-low `rst_n` asynchronously clears all 32 registers to zero.
- R10: With `ds_re` and `ds_we` both low, `io_sel` and `sram_sel` stay low. `ds_rdata` is 0x00 whenever `ds_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value (write-through) |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value (write-through) |
| wr_en | input | 1 | ALU result write enable |
| wr_idx | input | 5 | ALU result register index |
| wr_data | input | 8 | ALU result value |
| ptr_we | input | 1 | Pointer word write enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Pointer word value |
| ptr_x | output | 16 | X pointer word |
| ptr_y | output | 16 | Y pointer word |
| ptr_z | output | 16 | Z pointer word and table-lookup address |
| ds_addr | input | 16 | Data-space address |
| ds_re | input | 1 | Data-space read strobe |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write value |
| ds_rdata | output | 8 | Data-space read value |
| io_sel | output | 1 | I/O region selected |
| io_idx | output | 6 | I/O entry index |
| io_rdata | input | 8 | Read value from the I/O region |
| sram_sel | output | 1 | Data SRAM selected |
| sram_idx | output | 8 | Data SRAM byte index |
| sram_rdata | input | 8 | Read value from the data SRAM |

## Verification
The read ports, the data-space read bus, the selects and the indices are combinational, so they are due in the same cycle as their inputs. Every stored effect (ALU, pointer and data-space writes) appears one edge later, on the read ports and the pointer words. The bench drives inputs on the falling edge. It checks combinational results just after that, before the next rising edge. A write is checked only after one rising edge has passed, by reading the register or pointer back at the next falling edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [1:0] {
        PSEL_X    = 2'd0,
        PSEL_Y    = 2'd1,
        PSEL_Z    = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_GPR  = 2'd1,
        RG_IO   = 2'd2,
        RG_SRAM = 2'd3
    } ds_region_e;

endpackage

// File: rtl/rf_ds_decode.sv
module rf_ds_decode
    import rf_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NREG      = 32,
    parameter int IO_SIZE   = 64,
    parameter int SRAM_SIZE = 256,
    parameter int IW        = $clog2(NREG),
    parameter int IOW       = $clog2(IO_SIZE),
    parameter int SMW       = $clog2(SRAM_SIZE)
) (
    input  logic [AW-1:0]  ds_addr,
    output ds_region_e     region,
    output logic [IW-1:0]  reg_idx,
    output logic [IOW-1:0] io_idx,
    output logic [SMW-1:0] sram_idx
);
    localparam logic [AW-1:0] IO_BASE   = AW'(NREG);
    localparam logic [AW-1:0] SRAM_BASE = AW'(NREG + IO_SIZE);
    localparam logic [AW-1:0] SPACE_END = AW'(NREG + IO_SIZE + SRAM_SIZE);

    logic [AW-1:0] io_off;
    logic [AW-1:0] sram_off;

    always_comb begin
        io_off   = ds_addr - IO_BASE;
        sram_off = ds_addr - SRAM_BASE;
        reg_idx  = ds_addr[IW-1:0];
        io_idx   = io_off[IOW-1:0];
        sram_idx = sram_off[SMW-1:0];
        if (ds_addr < IO_BASE) begin
            region = RG_GPR;
        end else if (ds_addr < SRAM_BASE) begin
            region = RG_IO;
        end else if (ds_addr < SPACE_END) begin
            region = RG_SRAM;
        end else begin
            region = RG_NONE;
        end
    end
endmodule

// File: rtl/rf_wr_merge.sv
module rf_wr_merge
    import rf_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int DW       = 8,
    parameter int NPTR     = 3,
    parameter int PTR_BASE = 26,
    parameter int IW       = $clog2(NREG),
    parameter int PSW      = 2
) (
    input  logic [NREG-1:0][DW-1:0] regs_q,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    dsw_en,
    input  logic [IW-1:0]           dsw_idx,
    input  logic [DW-1:0]           dsw_data,
    input  logic                    ptr_we,
    input  logic [PSW-1:0]          ptr_sel,
    input  logic [2*DW-1:0]         ptr_wdata,
    output logic [NREG-1:0][DW-1:0] regs_nx
);
    logic          ptr_ok;
    logic [IW-1:0] ptr_lo_idx;
    logic [IW-1:0] ptr_hi_idx;

    always_comb begin
        ptr_ok     = ptr_we && (ptr_sel < PSW'(NPTR));
        ptr_lo_idx = IW'(PTR_BASE) + IW'({ptr_sel, 1'b0});
        ptr_hi_idx = ptr_lo_idx + IW'(1);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [IW-1:0] MY_IDX = IW'(i);
        always_comb begin
            if (ptr_ok && ptr_lo_idx == MY_IDX) begin
                regs_nx[i] = ptr_wdata[DW-1:0];
            end else if (ptr_ok && ptr_hi_idx == MY_IDX) begin
                regs_nx[i] = ptr_wdata[2*DW-1:DW];
            end else if (dsw_en && dsw_idx == MY_IDX) begin
                regs_nx[i] = dsw_data;
            end else if (wr_en && wr_idx == MY_IDX) begin
                regs_nx[i] = wr_data;
            end else begin
                regs_nx[i] = regs_q[i];
            end
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0] regs_view,
    input  logic [IW-1:0]           idx,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = regs_view[idx];
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import rf_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NREG      = 32,
    parameter int AW        = 16,
    parameter int IO_SIZE   = 64,
    parameter int SRAM_SIZE = 256,
    parameter int PTR_BASE  = 26,
    parameter int NPTR      = 3,
    parameter int IW        = $clog2(NREG),
    parameter int IOW       = $clog2(IO_SIZE),
    parameter int SMW       = $clog2(SRAM_SIZE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [IW-1:0]   rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            ptr_we,
    input  logic [1:0]      ptr_sel,
    input  logic [2*DW-1:0] ptr_wdata,
    output logic [2*DW-1:0] ptr_x,
    output logic [2*DW-1:0] ptr_y,
    output logic [2*DW-1:0] ptr_z,
    input  logic [AW-1:0]   ds_addr,
    input  logic            ds_re,
    input  logic            ds_we,
    input  logic [DW-1:0]   ds_wdata,
    output logic [DW-1:0]   ds_rdata,
    output logic            io_sel,
    output logic [IOW-1:0]  io_idx,
    input  logic [DW-1:0]   io_rdata,
    output logic            sram_sel,
    output logic [SMW-1:0]  sram_idx,
    input  logic [DW-1:0]   sram_rdata
);
    localparam int PX = PTR_BASE;
    localparam int PY = PTR_BASE + 2;
    localparam int PZ = PTR_BASE + 4;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } state_t;

    state_t                  state_d;
    state_t                  state_q;
    logic [NREG-1:0][DW-1:0] regs_nx;
    ds_region_e              region;
    logic [IW-1:0]           ds_reg_idx;
    logic [DW-1:0]           ds_reg_data;
    logic                    dsw_gpr;

    rf_ds_decode #(
        .AW(AW), .NREG(NREG), .IO_SIZE(IO_SIZE), .SRAM_SIZE(SRAM_SIZE),
        .IW(IW), .IOW(IOW), .SMW(SMW)
    ) u_dec (
        .ds_addr (ds_addr),
        .region  (region),
        .reg_idx (ds_reg_idx),
        .io_idx  (io_idx),
        .sram_idx(sram_idx)
    );

    assign dsw_gpr = ds_we && (region == RG_GPR);

    rf_wr_merge #(
        .NREG(NREG), .DW(DW), .NPTR(NPTR), .PTR_BASE(PTR_BASE), .IW(IW), .PSW(2)
    ) u_merge (
        .regs_q   (state_q.regs),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .dsw_en   (dsw_gpr),
        .dsw_idx  (ds_reg_idx),
        .dsw_data (ds_wdata),
        .ptr_we   (ptr_we),
        .ptr_sel  (ptr_sel),
        .ptr_wdata(ptr_wdata),
        .regs_nx  (regs_nx)
    );

    rf_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_a (
        .regs_view(regs_nx), .idx(rd_a_idx), .data(rd_a_data)
    );
    rf_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_b (
        .regs_view(regs_nx), .idx(rd_b_idx), .data(rd_b_data)
    );
    rf_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_ds (
        .regs_view(regs_nx), .idx(ds_reg_idx), .data(ds_reg_data)
    );

    always_comb begin
        state_d      = state_q;
        state_d.regs = regs_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ptr_x = {state_q.regs[PX+1], state_q.regs[PX]};
        ptr_y = {state_q.regs[PY+1], state_q.regs[PY]};
        ptr_z = {state_q.regs[PZ+1], state_q.regs[PZ]};
    end

    always_comb begin
        io_sel   = (ds_re || ds_we) && (region == RG_IO);
        sram_sel = (ds_re || ds_we) && (region == RG_SRAM);
        ds_rdata = '0;
        if (ds_re) begin
            unique case (region)
                RG_GPR:  ds_rdata = ds_reg_data;
                RG_IO:   ds_rdata = io_rdata;
                RG_SRAM: ds_rdata = sram_rdata;
                default: ds_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DW        = 8,
    parameter int NREG      = 32,
    parameter int AW        = 16,
    parameter int IO_SIZE   = 64,
    parameter int SRAM_SIZE = 256,
    parameter int PTR_BASE  = 26,
    parameter int IW        = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IW-1:0]   rd_a_idx,
    input logic [DW-1:0]   rd_a_data,
    input logic            wr_en,
    input logic [IW-1:0]   wr_idx,
    input logic [DW-1:0]   wr_data,
    input logic            ptr_we,
    input logic [1:0]      ptr_sel,
    input logic [2*DW-1:0] ptr_wdata,
    input logic [2*DW-1:0] ptr_x,
    input logic [2*DW-1:0] ptr_y,
    input logic [2*DW-1:0] ptr_z,
    input logic [AW-1:0]   ds_addr,
    input logic            ds_re,
    input logic            ds_we,
    input logic [DW-1:0]   ds_rdata,
    input logic            io_sel,
    input logic            sram_sel
);
    localparam logic [AW-1:0] SPACE_END = AW'(NREG + IO_SIZE + SRAM_SIZE);
    localparam logic [IW-1:0] Z_LO      = IW'(PTR_BASE + 4);

    // R9: after a sampled reset, every pointer word reads zero
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));

    // R4: a Z pointer write lands whole, whatever else targets the pair
    a_r4_ptr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel == 2'd2) |=> (ptr_z == $past(ptr_wdata)));

    // R1: a lone ALU write to the Z low register shows on the pointer word
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == Z_LO && !ptr_we && !ds_we)
        |=> (ptr_z[DW-1:0] == $past(wr_data)));

    // R2: a lone ALU write is visible on read port A in the same cycle
    a_r2_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_we && !ds_we && rd_a_idx == wr_idx)
        |-> (rd_a_data == wr_data));

    // R6: region selects never overlap
    a_r6_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_sel, sram_sel}));

    // R8: reads past the decoded space return zero with no select
    a_r8_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_re && ds_addr >= SPACE_END)
        |-> (ds_rdata == '0 && !io_sel && !sram_sel));

    // R10: no strobe, no select and no read data
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_re && !ds_we) |-> (!io_sel && !sram_sel && ds_rdata == '0));
endmodule

bind gpr_file rf_checker #(
    .DW(DW), .NREG(NREG), .AW(AW), .IO_SIZE(IO_SIZE),
    .SRAM_SIZE(SRAM_SIZE), .PTR_BASE(PTR_BASE), .IW(IW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .ds_addr(ds_addr), .ds_re(ds_re), .ds_we(ds_we), .ds_rdata(ds_rdata),
    .io_sel(io_sel), .sram_sel(sram_sel)
);

// File: tb/sim_gpr_file.sv
module sim_gpr_file;
    localparam int CLK_P    = 10;
    localparam int WATCHDOG = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
    logic        wr_en, ptr_we, ds_re, ds_we, io_sel, sram_sel;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_wdata, ptr_x, ptr_y, ptr_z, ds_addr;
    logic [5:0]  io_idx;
    logic [7:0]  sram_idx, io_rdata, sram_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int          which;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  chk_ev;

    gpr_file u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .ds_addr(ds_addr), .ds_re(ds_re), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .io_sel(io_sel), .io_idx(io_idx), .io_rdata(io_rdata),
        .sram_sel(sram_sel), .sram_idx(sram_idx), .sram_rdata(sram_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    localparam int O_RDA = 0, O_RDB = 1, O_PX = 2, O_PY = 3, O_PZ = 4,
                   O_DSR = 5, O_IOS = 6, O_IOI = 7, O_SMS = 8, O_SMI = 9;

    function automatic logic [15:0] get_out(int w);
        case (w)
            O_RDA:   return {8'h00, rd_a_data};
            O_RDB:   return {8'h00, rd_b_data};
            O_PX:    return ptr_x;
            O_PY:    return ptr_y;
            O_PZ:    return ptr_z;
            O_DSR:   return {8'h00, ds_rdata};
            O_IOS:   return {15'h0, io_sel};
            O_IOI:   return {10'h0, io_idx};
            O_SMS:   return {15'h0, sram_sel};
            default: return {8'h00, sram_idx};
        endcase
    endfunction

    // monitor: pops every queued expectation and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = get_out(it.which);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: output %0d actual=%h expected=%h",
                             it.req, it.which, act, it.exp);
                end
            end
        end
    end

    task automatic push(int w, logic [15:0] e, string r);
        item_t it;
        it.which = w;
        it.exp   = e;
        it.req   = r;
        q.push_back(it);
    endtask

    task automatic settle();
        #1;
        ->chk_ev;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        rd_a_idx = '0; rd_b_idx = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        ptr_we = 1'b0; ptr_sel = '0; ptr_wdata = '0;
        ds_addr = '0; ds_re = 1'b0; ds_we = 1'b0; ds_wdata = '0;
        io_rdata = 8'h6B; sram_rdata = 8'hD2;
    endtask

    task automatic alu_wr(logic [4:0] i, logic [7:0] d);
        clr(); wr_en = 1'b1; wr_idx = i; wr_data = d; tick(); clr();
    endtask

    task automatic ptr_wr(logic [1:0] s, logic [15:0] d);
        clr(); ptr_we = 1'b1; ptr_sel = s; ptr_wdata = d; tick(); clr();
    endtask

    task automatic ds_wr(logic [15:0] a, logic [7:0] d);
        clr(); ds_we = 1'b1; ds_addr = a; ds_wdata = d; tick(); clr();
    endtask

    task automatic rd2(logic [4:0] a, logic [7:0] ea, logic [4:0] b, logic [7:0] eb, string r);
        rd_a_idx = a; rd_b_idx = b;
        push(O_RDA, {8'h00, ea}, r);
        push(O_RDB, {8'h00, eb}, r);
        settle();
    endtask

    initial begin
        clr();
        @(negedge clk);
        @(negedge clk);
        // R9: registers clear while reset is held
        rd_a_idx = 5'd5;
        push(O_PX, 16'h0000, "R9"); push(O_PY, 16'h0000, "R9");
        push(O_PZ, 16'h0000, "R9"); push(O_RDA, 16'h0000, "R9");
        settle();
        rst_n = 1'b1;
        tick();

        // R1: ALU writes land at the edge, two independent reads
        alu_wr(5'd5, 8'hA5);
        rd2(5'd5, 8'hA5, 5'd6, 8'h00, "R1");
        alu_wr(5'd6, 8'h3C);
        rd2(5'd6, 8'h3C, 5'd5, 8'hA5, "R1");

        // R2: same-cycle read of the written register
        wr_en = 1'b1; wr_idx = 5'd7; wr_data = 8'h11;
        rd2(5'd7, 8'h11, 5'd5, 8'hA5, "R2");
        tick(); clr();
        rd2(5'd7, 8'h11, 5'd7, 8'h11, "R2");

        // R4 / R3: pointer word writes and byte order
        ptr_wr(2'd0, 16'h1234);
        push(O_PX, 16'h1234, "R4");
        rd2(5'd26, 8'h34, 5'd27, 8'h12, "R3");
        ptr_wr(2'd1, 16'hBEEF);
        ptr_wr(2'd2, 16'h0F80);
        push(O_PY, 16'hBEEF, "R4"); push(O_PZ, 16'h0F80, "R4");
        settle();

        // R3: ALU write to r31 shows on the Z word
        alu_wr(5'd31, 8'h77);
        push(O_PZ, 16'h7780, "R3");
        settle();

        // R4: pointer write beats ALU write to the same register
        clr(); ptr_we = 1'b1; ptr_sel = 2'd2; ptr_wdata = 16'hCAFE;
        wr_en = 1'b1; wr_idx = 5'd30; wr_data = 8'h55;
        rd_a_idx = 5'd30;
        push(O_RDA, 16'h00FE, "R4");
        settle();
        tick(); clr();
        push(O_PZ, 16'hCAFE, "R4");
        settle();

        // R4: select 3 changes nothing
        ptr_wr(2'd3, 16'hFFFF);
        push(O_PX, 16'h1234, "R4"); push(O_PY, 16'hBEEF, "R4");
        push(O_PZ, 16'hCAFE, "R4");
        rd2(5'd0, 8'h00, 5'd1, 8'h00, "R4");

        // R5: data-space access to registers
        ds_wr(16'h0003, 8'h9C);
        rd2(5'd3, 8'h9C, 5'd5, 8'hA5, "R5");
        ds_re = 1'b1; ds_addr = 16'h0005;
        push(O_DSR, 16'h00A5, "R5"); push(O_IOS, 16'h0000, "R5");
        settle(); clr();
        ds_wr(16'h001A, 8'h01);
        push(O_PX, 16'h1201, "R5");
        settle();
        clr(); ds_we = 1'b1; ds_addr = 16'h0008; ds_wdata = 8'h44;
        wr_en = 1'b1; wr_idx = 5'd8; wr_data = 8'h22;
        tick(); clr();
        rd2(5'd8, 8'h44, 5'd8, 8'h44, "R5");

        // R6: I/O region decode
        ds_re = 1'b1; ds_addr = 16'h0025;
        push(O_IOS, 16'h0001, "R6"); push(O_IOI, 16'h0005, "R6");
        push(O_SMS, 16'h0000, "R6"); push(O_DSR, 16'h006B, "R6");
        settle();
        ds_addr = 16'h005F;
        push(O_IOS, 16'h0001, "R6"); push(O_IOI, 16'h003F, "R6");
        push(O_SMS, 16'h0000, "R6");
        settle();
        clr(); ds_we = 1'b1; ds_addr = 16'h0020; ds_wdata = 8'hEE;
        push(O_IOS, 16'h0001, "R6"); push(O_IOI, 16'h0000, "R6");
        settle();
        tick(); clr();
        rd2(5'd0, 8'h00, 5'd1, 8'h00, "R6");

        // R7: SRAM region decode
        ds_re = 1'b1; ds_addr = 16'h0060;
        push(O_SMS, 16'h0001, "R7"); push(O_SMI, 16'h0000, "R7");
        push(O_IOS, 16'h0000, "R7"); push(O_DSR, 16'h00D2, "R7");
        settle();
        ds_addr = 16'h015F;
        push(O_SMS, 16'h0001, "R7"); push(O_SMI, 16'h00FF, "R7");
        settle();

        // R8: above the decoded space
        ds_addr = 16'h0160;
        push(O_DSR, 16'h0000, "R8"); push(O_IOS, 16'h0000, "R8");
        push(O_SMS, 16'h0000, "R8");
        settle(); clr();
        ds_wr(16'h0160, 8'hFF);
        rd2(5'd0, 8'h00, 5'd3, 8'h9C, "R8");
        ds_wr(16'hFFE3, 8'hFF);
        rd2(5'd3, 8'h9C, 5'd0, 8'h00, "R8");

        // R10: no strobes, no selects, no read data
        ds_addr = 16'h0025;
        push(O_IOS, 16'h0000, "R10"); push(O_DSR, 16'h0000, "R10");
        settle();
        ds_addr = 16'h0060;
        push(O_SMS, 16'h0000, "R10");
        settle();
        ds_addr = 16'h0005;
        push(O_DSR, 16'h0000, "R10");
        settle();
        clr();

        // R9: asynchronous reset mid-run
        rst_n = 1'b0;
        rd_a_idx = 5'd5; rd_b_idx = 5'd8;
        push(O_PX, 16'h0000, "R9"); push(O_PZ, 16'h0000, "R9");
        push(O_RDA, 16'h0000, "R9"); push(O_RDB, 16'h0000, "R9");
        settle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule